// File: doc/BRIEF.md
# I2C Pin Software Override

This block sits between an I2C engine and the two I2C pads. By default the engine's open-drain pull-low requests go straight to the pads. Software can hand both pins over to its own control with a single mode bit. It can then make each pin an output or an input, move the output levels up and down, and read back the synchronised pad levels. The typical use is to toggle the clock by hand to free a bus that a target holds low.

Software reaches the block through a 16-bit register port with one write strobe and a byte address. Reads are combinational from the address. The output latch is changed only through a write-one-to-set location and a write-one-to-clear location. A read-modify-write is therefore never needed to move one pin without disturbing the other. In every register, bit 0 refers to the clock pin (SCL) and bit 1 refers to the data pin (SDA).

Both pads are open-drain. A pad output enable of 1 pulls the pad low, and an enable of 0 releases it to the external pull-up.

Top module: `i2c_pin_override`

## Requirements
- R1: After reset, the mode, direction and output-latch registers read 0 and both pad enables follow the engine requests.
- R2: While the mode bit is 0, each pad enable equals the engine's pull-low request for that pin.
- R3: The mode register (byte address 0x0) stores bit 0 on a write; 1 selects software control. All other bits read 0.
- R4: The direction register (address 0x2) stores bits 0 and 1. A 1 makes SCL (bit 0) or SDA (bit 1) a software output. Upper bits read 0.
- R5: A write to the set location (address 0x6) forces the latch bits written as 1 to 1 and leaves the bits written as 0 unchanged. A read of this location returns the latch.
- R6: A write to the clear location (address 0x8) forces the latch bits written as 1 to 0 and leaves the bits written as 0 unchanged.
- R7: In software mode, a pin set as an output pulls its pad low when its latch bit is 0 and releases the pad when the latch bit is 1.
- R8: In software mode, a pin set as an input releases its pad whatever its latch bit holds, and the engine requests have no effect on either pad.
- R9: The input location (address 0x4) returns the SCL level in bit 0 and the SDA level in bit 1 in either mode. A pad change appears there after two clock edges and not after one. Writes to this location change nothing.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for read and write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr |
| engSclPullLow | input | 1 | Engine request to pull SCL low |
| engSdaPullLow | input | 1 | Engine request to pull SDA low |
| padSclIn | input | 1 | SCL pad level |
| padSdaIn | input | 1 | SDA pad level |
| padSclOe | output | 1 | SCL pad pull-low enable |
| padSdaOe | output | 1 | SDA pad pull-low enable |

## Verification
The bench builds the block with its default parameters. These are a 4-bit address, two synchroniser stages, and the five register locations at 0x0, 0x2, 0x4, 0x6 and 0x8. The small address space leaves spare codes such as 0xA, which the bench uses for the unmapped-address case. Two stages make the input latency short enough to check edge by edge, so the bench can show that a pad change is still hidden after one edge and visible after the second.

// File: rtl/pin_ovr_pkg.sv
package pin_ovr_pkg;

  typedef enum logic [2:0] {
    RD_NONE  = 3'd0,
    RD_MODE  = 3'd1,
    RD_DIR   = 3'd2,
    RD_LEVEL = 3'd3,
    RD_LATCH = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   modeWr;
    logic   dirWr;
    logic   setWr;
    logic   clrWr;
    rdSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/pin_ovr_ctrl.sv
module pin_ovr_ctrl
  import pin_ovr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MODE_OFS   = 'h0,
  parameter int DIR_OFS    = 'h2,
  parameter int LEVEL_OFS  = 'h4,
  parameter int SET_OFS    = 'h6,
  parameter int CLR_OFS    = 'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrb_t         strb
);

  localparam logic [ADDR_W-1:0] ModeA  = ADDR_W'(MODE_OFS);
  localparam logic [ADDR_W-1:0] DirA   = ADDR_W'(DIR_OFS);
  localparam logic [ADDR_W-1:0] LevelA = ADDR_W'(LEVEL_OFS);
  localparam logic [ADDR_W-1:0] SetA   = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] ClrA   = ADDR_W'(CLR_OFS);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (regAddr == ModeA) begin
      strb.rdSel  = RD_MODE;
      strb.modeWr = regWr;
    end else if (regAddr == DirA) begin
      strb.rdSel = RD_DIR;
      strb.dirWr = regWr;
    end else if (regAddr == LevelA) begin
      strb.rdSel = RD_LEVEL;
    end else if (regAddr == SetA) begin
      strb.rdSel = RD_LATCH;
      strb.setWr = regWr;
    end else if (regAddr == ClrA) begin
      strb.rdSel = RD_LATCH;
      strb.clrWr = regWr;
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.modeWr, strb.dirWr, strb.setWr, strb.clrWr})); // R10
  AST_NO_WR_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |-> !(strb.modeWr || strb.dirWr || strb.setWr || strb.clrWr)); // R10

endmodule

// File: rtl/pin_ovr_datapath.sv
module pin_ovr_datapath
  import pin_ovr_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] engPullLow,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [DATA_W-1:0]   rdData
);

  logic                modeSel;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] latchQ;
  logic [NUM_PINS-1:0] pinLevel;
  logic [NUM_PINS-1:0] wrBits;

  assign wrBits = wrData[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSel <= 1'b0;
      dirQ    <= '0;
      latchQ  <= '0;
    end else begin
      if (strb.modeWr) modeSel <= wrData[0];
      if (strb.dirWr)  dirQ    <= wrBits;
      if (strb.setWr)       latchQ <= latchQ | wrBits;
      else if (strb.clrWr)  latchQ <= latchQ & ~wrBits;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncChain;

    always_ff @(posedge clk) begin
      if (!rstN) syncChain <= '1;
      else       syncChain <= {syncChain[SYNC_STAGES-2:0], padIn[i]};
    end

    assign pinLevel[i] = syncChain[SYNC_STAGES-1];
    assign padOe[i]    = modeSel ? (dirQ[i] & ~latchQ[i]) : engPullLow[i];

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
      (modeSel && !dirQ[i]) |-> !padOe[i]); // R8
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_MODE:  rdData[0]            = modeSel;
      RD_DIR:   rdData[NUM_PINS-1:0] = dirQ;
      RD_LEVEL: rdData[NUM_PINS-1:0] = pinLevel;
      RD_LATCH: rdData[NUM_PINS-1:0] = latchQ;
      default:  rdData = '0;
    endcase
  end

  AST_SET_HITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> ((latchQ & $past(wrBits)) == $past(wrBits))); // R5
  AST_CLR_HITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |=> ((latchQ & $past(wrBits)) == '0)); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setWr && !strb.clrWr) |=> $stable(latchQ)); // R5
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWr |=> (modeSel == $past(wrData[0]))); // R3
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirWr |=> (dirQ == $past(wrBits))); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dirWr |=> $stable(dirQ)); // R10

endmodule

// File: rtl/i2c_pin_override.sv
module i2c_pin_override
  import pin_ovr_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              engSclPullLow,
  input  logic              engSdaPullLow,
  input  logic              padSclIn,
  input  logic              padSdaIn,
  output logic              padSclOe,
  output logic              padSdaOe
);

  localparam int NumPins = 2;
  localparam int DataW   = 16;

  ctrlStrb_t          strb;
  logic [NumPins-1:0] engVec;
  logic [NumPins-1:0] padInVec;
  logic [NumPins-1:0] padOeVec;

  assign engVec   = {engSdaPullLow, engSclPullLow};
  assign padInVec = {padSdaIn, padSclIn};
  assign padSclOe = padOeVec[0];
  assign padSdaOe = padOeVec[1];

  pin_ovr_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regWr  (regWr),
    .regAddr(regAddr),
    .strb   (strb)
  );

  pin_ovr_datapath #(
    .NUM_PINS   (NumPins),
    .DATA_W     (DataW),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (regWrData),
    .engPullLow(engVec),
    .padIn     (padInVec),
    .padOe     (padOeVec),
    .rdData    (regRdData)
  );

endmodule

// File: tb/i2c_pin_override_test.sv
module i2c_pin_override_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        engSclPullLow = 1'b0;
  logic        engSdaPullLow = 1'b0;
  logic        padSclOe, padSdaOe;
  logic [1:0]  extLow = 2'b00;
  logic        padSclIn, padSdaIn;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign padSclIn = ~padSclOe & ~extLow[0];
  assign padSdaIn = ~padSdaOe & ~extLow[1];

  i2c_pin_override uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .engSclPullLow(engSclPullLow), .engSdaPullLow(engSdaPullLow),
    .padSclIn(padSclIn), .padSdaIn(padSdaIn),
    .padSclOe(padSclOe), .padSdaOe(padSdaOe)
  );

  // wr, addr, data, eng{sda,scl}, expected oe{sda,scl}, expected read, req tag
  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [1:0]  eng;
    logic [1:0]  expOe;
    logic [15:0] expRd;
  } vec_t;

  localparam int NumVecs = 13;
  localparam vec_t Vecs [NumVecs] = '{
    '{1'b0, 4'h0, 16'h0000, 2'b01, 2'b01, 16'h0000}, // R2 engine mode
    '{1'b1, 4'h0, 16'hFFFF, 2'b11, 2'b00, 16'h0001}, // R3 R8 mode on
    '{1'b1, 4'h2, 16'h0001, 2'b11, 2'b01, 16'h0001}, // R4 R7 scl out low
    '{1'b1, 4'h6, 16'h0001, 2'b11, 2'b00, 16'h0001}, // R5 scl released
    '{1'b1, 4'h2, 16'h0003, 2'b11, 2'b10, 16'h0003}, // R4 R7 sda out low
    '{1'b1, 4'h6, 16'h0002, 2'b11, 2'b00, 16'h0003}, // R5 keep bit0
    '{1'b1, 4'h8, 16'h0001, 2'b11, 2'b01, 16'h0002}, // R6 clr scl
    '{1'b1, 4'h8, 16'h0000, 2'b11, 2'b01, 16'h0002}, // R6 zero no effect
    '{1'b1, 4'h2, 16'h0000, 2'b11, 2'b00, 16'h0000}, // R8 inputs released
    '{1'b1, 4'hA, 16'hFFFF, 2'b11, 2'b00, 16'h0000}, // R10 unmapped
    '{1'b1, 4'h0, 16'h0000, 2'b10, 2'b10, 16'h0000}, // R2 back to engine
    '{1'b1, 4'h8, 16'h0003, 2'b00, 2'b00, 16'h0000}, // R6 clr in engine mode
    '{1'b1, 4'h4, 16'hFFFF, 2'b00, 2'b00, 16'h0003}  // R9 input read-only
  };

  function automatic string reqOf(input int idx);
    case (idx)
      0, 10:     return "R2";
      1:         return "R3";
      2, 4:      return "R4/R7";
      3, 5:      return "R5";
      6, 7, 11:  return "R6";
      8:         return "R8";
      9:         return "R10";
      default:   return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readAt(input logic [3:0] a);
    @(negedge clk);
    regWr = 1'b0;
    regAddr = a;
    #1;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1;
    regAddr = a;
    regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    engSclPullLow = 1'b1;
    #1;
    // R1 reset state
    check("R1", "oe during reset", {14'h0, padSdaOe, padSclOe}, 16'h0001);
    rstN = 1'b1;
    readAt(4'h0); check("R1", "mode after reset", regRdData, 16'h0000);
    readAt(4'h2); check("R1", "dir after reset", regRdData, 16'h0000);
    readAt(4'h6); check("R1", "latch after reset", regRdData, 16'h0000);

    for (int i = 0; i < NumVecs; i++) begin
      @(negedge clk);
      regWr = Vecs[i].wr;
      regAddr = Vecs[i].addr;
      regWrData = Vecs[i].data;
      {engSdaPullLow, engSclPullLow} = Vecs[i].eng;
      @(negedge clk);
      regWr = 1'b0;
      if (Vecs[i].addr == 4'h8) regAddr = 4'h6;
      #1;
      check(reqOf(i), $sformatf("vec %0d pad oe", i),
            {14'h0, padSdaOe, padSclOe}, {14'h0, Vecs[i].expOe});
      check(reqOf(i), $sformatf("vec %0d read", i), regRdData, Vecs[i].expRd);
    end

    // R9 synchroniser latency: engine mode, pads released, pull SCL externally
    readAt(4'h4);
    check("R9", "levels idle", regRdData, 16'h0003);
    @(negedge clk);
    extLow = 2'b01;
    @(posedge clk); #1;
    check("R9", "after one edge", regRdData, 16'h0003);
    @(posedge clk); #1;
    check("R9", "after two edges", regRdData, 16'h0002);
    extLow = 2'b00;

    // R9 input visible in software mode as well (SDA driven low by latch 0)
    writeReg(4'h0, 16'h0001);
    writeReg(4'h2, 16'h0002);
    readAt(4'h4);
    @(posedge clk); #1;
    check("R9", "sda level in sw mode", regRdData, 16'h0001);
    check("R7", "sda oe in sw mode", {14'h0, padSdaOe, padSclOe}, 16'h0002);

    // R1 reset mid-run returns control to engine
    writeReg(4'h6, 16'h0003);
    @(negedge clk);
    rstN = 1'b0;
    engSclPullLow = 1'b0;
    engSdaPullLow = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1", "oe after mid reset", {14'h0, padSdaOe, padSclOe}, 16'h0002);
    readAt(4'h0); check("R1", "mode after mid reset", regRdData, 16'h0000);
    readAt(4'h6); check("R1", "latch after mid reset", regRdData, 16'h0000);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog all-reqs actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule